// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

This block is a 32-bit processor core that finishes each instruction within one clock period. In that period it fetches a word from its own instruction memory, decodes it, reads two operands from a 32-entry register file, runs an add, subtract or OR in the ALU, optionally reads or writes its own data memory, and writes the result back. At the rising edge the program counter and any register or memory write commit together.

Six operations are implemented: register add and subtract (no overflow trap), OR with a zero-extended immediate, word load, word store, and branch-if-equal. Equality for the branch comes from the ALU subtract result being zero. Every other encoding retires as a no-op. Both memories are loaded from outside through a word-indexed load port, normally while reset is held. Stores that the core performs are mirrored on a store-monitor output, and the current program counter is visible on `pc_o`.

Top module: `sc_core`

## Requirements
- R1: While `rst_ni` is low the PC reads 0, no store is signalled, and every register reads 0; after release the instruction at byte address 0 runs first.
- R2: Opcode 0x00 with funct 0x21 writes rs + rt, modulo 2^32, into rd (rd in bits 15:11, rs in 25:21, rt in 20:16).
- R3: Opcode 0x00 with funct 0x23 writes rs - rt, modulo 2^32, into rd.
- R4: Opcode 0x0D writes rs OR the zero-extended bits 15:0 into rt.
- R5: Opcode 0x23 loads rt from the data word at rs + sign-extended bits 15:0.
- R6: Opcode 0x2B stores rt to the data word at rs + sign-extended bits 15:0; in that cycle `st_we_o` is 1, `st_addr_o` holds the byte address and `st_data_o` the value stored.
- R7: Opcode 0x04 sets the next PC to PC + 4 + (sign-extended bits 15:0 << 2) when rs equals rt, else PC + 4; every other instruction sets it to PC + 4.
- R8: Register 0 always reads 0; writes aimed at it have no effect.
- R9: Any opcode other than 0x00, 0x0D, 0x23, 0x2B and 0x04, and opcode 0x00 with a funct other than 0x21 or 0x23, changes no register and no memory and advances the PC by 4.
- R10: Data addresses are byte addresses; their two low bits are dropped when selecting a word.
- R11: A load-port write with `ld_imem_we_i` or `ld_dmem_we_i` high stores `ld_data_i` at word index `ld_addr_i` of that memory at the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state commits on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ld_imem_we_i | input | 1 | Load-port write enable for instruction memory |
| ld_dmem_we_i | input | 1 | Load-port write enable for data memory |
| ld_addr_i | input | $clog2(MEM_WORDS) | Load-port word index |
| ld_data_i | input | XLEN | Load-port write data |
| pc_o | output | XLEN | Current program counter (byte address) |
| st_we_o | output | 1 | High in a cycle whose instruction stores to data memory |
| st_addr_o | output | XLEN | Byte address of that store |
| st_data_o | output | XLEN | Data of that store |

## Verification
The bench builds the core with its defaults, XLEN of 32, 32 registers and 64-word memories, so every address used by the test programs, including the word reached through a negative load offset and the unaligned byte address 39, falls inside both memories without wrap. With 32-bit data the subtract case can borrow through all upper bits and the OR immediate sits against a 0xFFFF boundary, which exposes sign and zero extension mistakes. Short programs ending in a self-branch let the final PC be compared exactly, which checks both the taken and the fall-through branch paths.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] FN_ADDU  = 6'h21;
  localparam logic [5:0] FN_SUBU  = 6'h23;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR} alu_op_e;

  typedef struct packed {
    logic    rf_we;
    logic    dst_rd;   // write rd instead of rt
    logic    use_imm;
    logic    sext;
    alu_op_e alu_op;
    logic    mem_we;
    logic    mem_rd;
    logic    branch;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    unique case (op_i)
      OP_RTYPE: begin
        if (funct_i == FN_ADDU || funct_i == FN_SUBU) begin
          ctrl_o.rf_we  = 1'b1;
          ctrl_o.dst_rd = 1'b1;
          ctrl_o.alu_op = (funct_i == FN_SUBU) ? ALU_SUB : ALU_ADD;
        end
      end
      OP_ORI: begin
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.use_imm = 1'b1;
        ctrl_o.alu_op  = ALU_OR;
      end
      OP_LW: begin
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.use_imm = 1'b1;
        ctrl_o.sext    = 1'b1;
        ctrl_o.mem_rd  = 1'b1;
      end
      OP_SW: begin
        ctrl_o.use_imm = 1'b1;
        ctrl_o.sext    = 1'b1;
        ctrl_o.mem_we  = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.sext   = 1'b1;
        ctrl_o.alu_op = ALU_SUB;
        ctrl_o.branch = 1'b1;
      end
      default: ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   ra_i,
  input  logic [AW-1:0]   rb_i,
  input  logic [AW-1:0]   rw_i,
  input  logic            we_i,
  input  logic [XLEN-1:0] wd_i,
  output logic [XLEN-1:0] a_o,
  output logic [XLEN-1:0] b_o
);
  logic [XLEN-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && rw_i != '0) begin
      regs_q[rw_i] <= wd_i;
    end
  end

  assign a_o = (ra_i == '0) ? '0 : regs_q[ra_i];
  assign b_o = (rb_i == '0) ? '0 : regs_q[rb_i];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  alu_op_e         op_i,
  output logic [XLEN-1:0] y_o,
  output logic            zero_o
);
  always_comb begin
    unique case (op_i)
      ALU_SUB: y_o = a_i - b_i;
      ALU_OR:  y_o = a_i | b_i;
      default: y_o = a_i + b_i;
    endcase
  end
  assign zero_o = (y_o == '0);
endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
  parameter int XLEN  = 32,
  parameter int WORDS = 64,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic            clk_i,
  input  logic            we_i,
  input  logic [IW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [IW-1:0]   raddr_i,
  output logic [XLEN-1:0] rdata_o
);
  logic [XLEN-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int NREG      = 32,
  parameter int MEM_WORDS = 64,
  localparam int IW       = $clog2(MEM_WORDS),
  localparam int RAW      = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ld_imem_we_i,
  input  logic            ld_dmem_we_i,
  input  logic [IW-1:0]   ld_addr_i,
  input  logic [XLEN-1:0] ld_data_i,
  output logic [XLEN-1:0] pc_o,
  output logic            st_we_o,
  output logic [XLEN-1:0] st_addr_o,
  output logic [XLEN-1:0] st_data_o
);
  logic [XLEN-1:0] pc_q, pc_d, pc_plus4, br_tgt;
  logic [XLEN-1:0] instr, imm_ext, ra_val, rb_val, alu_b, alu_y, dm_rdata, wb_val;
  logic [RAW-1:0]  rw_addr;
  logic            alu_zero, rf_we, core_st;
  ctrl_t           ctrl;

  // fetch
  sc_mem #(.XLEN(XLEN), .WORDS(MEM_WORDS)) u_imem (
    .clk_i, .we_i(ld_imem_we_i), .waddr_i(ld_addr_i), .wdata_i(ld_data_i),
    .raddr_i(pc_q[IW+1:2]), .rdata_o(instr)
  );

  // decode / operand read
  sc_decode u_dec (.op_i(instr[31:26]), .funct_i(instr[5:0]), .ctrl_o(ctrl));

  assign imm_ext = ctrl.sext ? {{(XLEN-16){instr[15]}}, instr[15:0]}
                             : {{(XLEN-16){1'b0}}, instr[15:0]};
  assign rw_addr = ctrl.dst_rd ? instr[15:11] : instr[20:16];
  assign rf_we   = ctrl.rf_we & rst_ni;

  sc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk_i, .rst_ni, .ra_i(instr[25:21]), .rb_i(instr[20:16]), .rw_i(rw_addr),
    .we_i(rf_we), .wd_i(wb_val), .a_o(ra_val), .b_o(rb_val)
  );

  // execute
  assign alu_b = ctrl.use_imm ? imm_ext : rb_val;
  sc_alu #(.XLEN(XLEN)) u_alu (
    .a_i(ra_val), .b_i(alu_b), .op_i(ctrl.alu_op), .y_o(alu_y), .zero_o(alu_zero)
  );

  // memory: load port has priority over the core
  assign core_st = ctrl.mem_we & rst_ni;
  sc_mem #(.XLEN(XLEN), .WORDS(MEM_WORDS)) u_dmem (
    .clk_i, .we_i(ld_dmem_we_i | core_st),
    .waddr_i(ld_dmem_we_i ? ld_addr_i : alu_y[IW+1:2]),
    .wdata_i(ld_dmem_we_i ? ld_data_i : rb_val),
    .raddr_i(alu_y[IW+1:2]), .rdata_o(dm_rdata)
  );

  // write-back
  assign wb_val = ctrl.mem_rd ? dm_rdata : alu_y;

  // next address
  assign pc_plus4 = pc_q + XLEN'(4);
  assign br_tgt   = pc_plus4 + (imm_ext << 2);
  assign pc_d     = (ctrl.branch && alu_zero) ? br_tgt : pc_plus4;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o      = pc_q;
  assign st_we_o   = core_st;
  assign st_addr_o = alu_y;
  assign st_data_o = rb_val;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [XLEN-1:0] pc_i,
  input logic [5:0]      op_i,
  input logic [4:0]      ra_i,
  input logic [XLEN-1:0] ra_val_i,
  input logic [XLEN-1:0] rb_val_i,
  input logic [XLEN-1:0] imm_i,
  input logic            st_we_i,
  input logic            rf_we_i
);
  // R7: sequential step for non-branch instructions
  a_r7_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != OP_BEQ) |=> pc_i == $past(pc_i) + XLEN'(4));

  // R7: taken branch, equality judged from register values
  a_r7_beq_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_BEQ && ra_val_i == rb_val_i)
      |=> pc_i == $past(pc_i) + XLEN'(4) + ($past(imm_i) << 2));

  // R7: branch falls through
  a_r7_beq_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_BEQ && ra_val_i != rb_val_i) |=> pc_i == $past(pc_i) + XLEN'(4));

  // R8: register 0 reads zero
  a_r8_x0_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_i == 5'd0) |-> ra_val_i == '0);

  // R6: store strobe only for the store opcode
  a_r6_store_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_we_i |-> op_i == OP_SW);

  // R9: register write only for writing opcodes
  a_r9_no_stray_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_i |-> (op_i == OP_RTYPE || op_i == OP_ORI || op_i == OP_LW));
endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pc_i    (pc_q),
  .op_i    (instr[31:26]),
  .ra_i    (instr[25:21]),
  .ra_val_i(ra_val),
  .rb_val_i(rb_val),
  .imm_i   (imm_ext),
  .st_we_i (st_we_o),
  .rf_we_i (rf_we)
);

// File: tb/tb_sc_core.sv
`timescale 1ns/1ps
module tb_sc_core;
  localparam int XLEN = 32;
  localparam int MW   = 64;
  localparam int IW   = $clog2(MW);

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            ld_imem_we_i = 1'b0;
  logic            ld_dmem_we_i = 1'b0;
  logic [IW-1:0]   ld_addr_i = '0;
  logic [XLEN-1:0] ld_data_i = '0;
  logic [XLEN-1:0] pc_o, st_addr_o, st_data_o;
  logic            st_we_o;

  sc_core #(.XLEN(XLEN), .NREG(32), .MEM_WORDS(MW)) dut (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] prog [16];
  logic [31:0] log_a [16];
  logic [31:0] log_d [16];
  int nlog = 0;

  always @(negedge clk_i)
    if (rst_ni && st_we_o && nlog < 16) begin
      log_a[nlog] = st_addr_o;
      log_d[nlog] = st_data_o;
      nlog++;
    end

  function automatic logic [31:0] enc_r(int fn, int rs, int rt, int rd);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ld(bit imem, int idx, logic [31:0] d);
    ld_imem_we_i = imem;
    ld_dmem_we_i = !imem;
    ld_addr_i = idx[IW-1:0];
    ld_data_i = d;
    @(negedge clk_i);
    ld_imem_we_i = 1'b0;
    ld_dmem_we_i = 1'b0;
  endtask

  // reset held while loading (R11), released between edges, then run
  task automatic run(int n, int cycles);
    rst_ni = 1'b0;
    nlog = 0;
    for (int i = 0; i < n; i++) ld(1'b1, i, prog[i]);
    @(posedge clk_i); #5 rst_ni = 1'b1;
    repeat (cycles) @(negedge clk_i);
  endtask

  task automatic t_arith();
    prog[0] = enc_i(13, 0, 1, 'hFFFF);
    prog[1] = enc_i(13, 0, 2, 5);
    prog[2] = enc_r(33, 1, 2, 3);
    prog[3] = enc_r(35, 2, 1, 4);
    prog[4] = enc_i(13, 2, 5, 'h8000);
    prog[5] = enc_i(43, 0, 3, 0);
    prog[6] = enc_i(43, 0, 4, 4);
    prog[7] = enc_i(43, 0, 1, 8);
    prog[8] = enc_i(43, 0, 5, 12);
    prog[9] = enc_i(4, 0, 0, -1);
    run(10, 20);
    chk("R6 store count", nlog, 4);
    chk("R2 addu", log_d[0], 32'h0001_0004);
    chk("R6 store addr", log_a[0], 32'd0);
    chk("R3 subu borrow", log_d[1], 32'hFFFF_0006);
    chk("R4 ori zero-ext", log_d[2], 32'h0000_FFFF);
    chk("R4 ori with rs", log_d[3], 32'h0000_8005);
    chk("R7 halt pc", pc_o, 32'd36);
  endtask

  task automatic t_load();
    rst_ni = 1'b0;
    ld(1'b0, 3, 32'hCAFE_F00D);
    ld(1'b0, 1, 32'h1111_1111);
    prog[0] = enc_i(13, 0, 1, 16);
    prog[1] = enc_i(35, 1, 2, -4);
    prog[2] = enc_i(35, 0, 4, 6);
    prog[3] = enc_i(43, 0, 2, 32);
    prog[4] = enc_i(43, 0, 4, 36);
    prog[5] = enc_i(43, 0, 2, 39);
    prog[6] = enc_i(35, 0, 6, 36);
    prog[7] = enc_i(43, 0, 6, 44);
    prog[8] = enc_i(4, 0, 0, -1);
    run(9, 20);
    chk("R5 load count", nlog, 4);
    chk("R5 lw negative offset", log_d[0], 32'hCAFE_F00D);
    chk("R11 preload word", log_d[0], 32'hCAFE_F00D);
    chk("R10 lw low bits ignored", log_d[1], 32'h1111_1111);
    chk("R6 store addr", log_a[1], 32'd36);
    chk("R10 store byte addr", log_a[2], 32'd39);
    chk("R10 store word overwritten", log_d[3], 32'hCAFE_F00D);
  endtask

  task automatic t_branch();
    prog[0] = enc_i(13, 0, 1, 7);
    prog[1] = enc_i(13, 0, 2, 7);
    prog[2] = enc_i(13, 0, 3, 8);
    prog[3] = enc_i(4, 1, 3, 1);
    prog[4] = enc_i(43, 0, 1, 0);
    prog[5] = enc_i(4, 1, 2, 1);
    prog[6] = enc_i(43, 0, 3, 4);
    prog[7] = enc_i(43, 0, 2, 8);
    prog[8] = enc_i(4, 0, 0, -1);
    run(9, 20);
    chk("R7 store count", nlog, 2);
    chk("R7 not taken", log_a[0], 32'd0);
    chk("R7 taken skips", log_a[1], 32'd8);
    chk("R7 taken data", log_d[1], 32'd7);
    chk("R7 backward self branch", pc_o, 32'd32);
  endtask

  task automatic t_nop();
    prog[0] = enc_i(13, 0, 2, 9);
    prog[1] = enc_i(13, 0, 0, 'h55);
    prog[2] = enc_r(33, 2, 2, 0);
    prog[3] = enc_r(37, 2, 2, 9);
    prog[4] = {6'h3F, 5'd2, 5'd9, 16'h0007};
    prog[5] = enc_i(8, 2, 9, 3);
    prog[6] = enc_i(43, 0, 0, 0);
    prog[7] = enc_i(43, 0, 9, 4);
    prog[8] = enc_i(43, 0, 2, 8);
    prog[9] = enc_i(4, 0, 0, -1);
    run(10, 20);
    chk("R9 flow continues", nlog, 3);
    chk("R8 r0 stays zero", log_d[0], 32'd0);
    chk("R9 unknown codes no write", log_d[1], 32'd0);
    chk("R9 later data intact", log_d[2], 32'd9);
    chk("R9 pc advanced", pc_o, 32'd36);
  endtask

  task automatic t_reset();
    prog[0] = enc_i(43, 0, 5, 0);
    prog[1] = enc_i(4, 0, 0, -1);
    rst_ni = 1'b0;
    nlog = 0;
    ld(1'b1, 0, prog[0]);
    ld(1'b1, 1, prog[1]);
    chk("R1 pc in reset", pc_o, 32'd0);
    chk("R1 no store in reset", {31'd0, st_we_o}, 32'd0);
    @(posedge clk_i); #5 rst_ni = 1'b1;
    repeat (6) @(negedge clk_i);
    chk("R1 first instr runs", nlog, 1);
    chk("R1 registers cleared", log_d[0], 32'd0);
    chk("R1 halt pc", pc_o, 32'd4);
  endtask

  initial begin
    @(negedge clk_i);
    t_arith();
    t_load();
    t_branch();
    t_nop();
    t_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule